// File: doc/BRIEF.md
# Oscillator Drift Trimmer

This block derives the one-second tick of a real-time clock from a 32.768 kHz oscillator and trims that oscillator's frequency error. A prescaler counts oscillator cycles and fires a one-cycle seconds tick at the end of each nominal period. Software programs a correction as a whole number of oscillator cycles, between 0 and 63, and a direction. Once per correction interval, the prescaler period that ends the interval is shortened or lengthened by that many cycles. The interval is either 10 or 60 seconds.

The block counts seconds ticks from reset to locate interval boundaries. In short mode a boundary falls after every tenth second. In long mode it falls after every sixtieth. One cycle of correction per 10 s is worth about 1e9/(10·f) parts per billion, and per 60 s about 1e9/(60·f). Working out the correction value and keeping the calendar beyond the seconds tick are left to the surrounding logic.

Software may change the interval only while the direction code is zero. A write that tries to change the interval while a correction is armed leaves the interval as it was.

Top module: `drift_trim`

## Requirements
- R1: After reset, the trim word reads 0, automatic trimming is off, long (60 s) mode is selected, and the first seconds tick appears exactly PRESC_CYCLES cycles after reset is released.
- R2: A trim-word write stores all 8 bits, which read back unchanged on the next cycle. Bits 5:0 hold the cycle count N and bits 7:6 hold the direction code.
- R3: While automatic trimming is off, every seconds period lasts PRESC_CYCLES cycles, whatever the trim word holds.
- R4: A period that does not end an interval lasts PRESC_CYCLES cycles.
- R5: With trimming on and direction code 1 (add), the period that ends an interval lasts PRESC_CYCLES − N cycles.
- R6: With trimming on and direction code 2 (subtract), the period that ends an interval lasts PRESC_CYCLES + N cycles.
- R7: Direction codes 0 and 3 leave every period at PRESC_CYCLES cycles, whatever N is.
- R8: With the interval bit at 1 (short mode), the period of zero-based second index s ends an interval when s mod 10 = 9. With the interval bit at 0 (long mode), it ends an interval when s mod 60 = 59.
- R9: A control write always updates the trim-enable bit. It updates the interval bit only if the stored direction code is 0; otherwise the interval bit keeps its value.
- R10: Second indices count every tick since reset, and a change of interval does not restart them.
- R11: A count of N = 0 with either add or subtract leaves the boundary period at PRESC_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trim_wr | input | 1 | Write strobe for the trim word |
| trim_wdata | input | 8 | Trim word: [7:6] direction, [5:0] cycle count |
| ctl_wr | input | 1 | Write strobe for the control bits |
| ctl_trim_en | input | 1 | New value of the trim-enable bit |
| ctl_short_ivl | input | 1 | New interval bit (1 = 10 s, 0 = 60 s) |
| trim_q | output | 8 | Stored trim word |
| trim_en_q | output | 1 | Stored trim-enable bit |
| short_ivl_q | output | 1 | Stored interval bit |
| sec_tick | output | 1 | One-cycle pulse at the end of each seconds period |
| period_len | output | $clog2(PRESC_CYCLES+64) | Terminal count of the current period (length − 1) |

## Verification
The bench sweeps the cycle count over values from 0 to 63 with all four direction codes in short mode. Each setting runs long enough to span at least one boundary, so the shortened, lengthened and untouched periods are each measured against the non-boundary periods around them. Long mode is run with trimming off, then on with subtract, add and the reserved code, so that the 60 s boundary can be told apart from the 10 s one. The bench also tries an interval change while a direction is armed, then again after clearing it, and checks that the boundaries keep counting from reset across the mode switch.

// File: rtl/drift_trim_pkg.sv
// Shared field layout of the trim word.
package drift_trim_pkg;

    localparam int TRIM_CW = 6;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_ADD  = 2'd1,
        DIR_SUB  = 2'd2,
        DIR_RSVD = 2'd3
    } trim_dir_e;

    typedef struct packed {
        trim_dir_e           dir;
        logic [TRIM_CW-1:0]  cnt;
    } trim_word_t;

endpackage

// File: rtl/drift_trim_regs.sv
// Trim word and control bits.
// The interval bit is locked while a direction code is armed.
// Assumes the writes are synchronous to clk.
module drift_trim_regs
    import drift_trim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trim_wr,
    input  logic [7:0] trim_wdata,
    input  logic       ctl_wr,
    input  logic       ctl_trim_en,
    input  logic       ctl_short_ivl,
    output trim_word_t trim_q,
    output logic       trim_en_q,
    output logic       short_ivl_q
);

    // Store the trim word.
    always_ff @(posedge clk) begin
        if (!rst_n)       trim_q <= '0;
        else if (trim_wr) trim_q <= trim_word_t'(trim_wdata);
    end

    // Store the control bits; the interval bit changes only while no direction is armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_en_q   <= 1'b0;
            short_ivl_q <= 1'b0;
        end else if (ctl_wr) begin
            trim_en_q <= ctl_trim_en;
            if (trim_q.dir == DIR_NONE) short_ivl_q <= ctl_short_ivl;
        end
    end

    // R9
    ivl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_ivl_q != $past(short_ivl_q)) |-> ($past(ctl_wr) && $past(trim_q.dir) == DIR_NONE));

endmodule

// File: rtl/drift_sec_track.sv
// Counts seconds ticks since reset and flags the period that closes an interval.
// Assumes LONG_SECS is a multiple of SHORT_SECS.
module drift_sec_track #(
    parameter int SHORT_SECS = 10,
    parameter int LONG_SECS  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic short_ivl,
    output logic last_sec
);

    localparam int GROUPS = LONG_SECS / SHORT_SECS;
    localparam int UW     = (SHORT_SECS > 1) ? $clog2(SHORT_SECS) : 1;
    localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    logic [UW-1:0] units;
    logic [GW-1:0] group;

    // Advance the two-level seconds counter on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            units <= '0;
            group <= '0;
        end else if (sec_tick) begin
            if (units == UW'(SHORT_SECS - 1)) begin
                units <= '0;
                group <= (group == GW'(GROUPS - 1)) ? '0 : group + 1'b1;
            end else begin
                units <= units + 1'b1;
            end
        end
    end

    // Flag the final second of a short or long interval.
    always_comb begin
        last_sec = (units == UW'(SHORT_SECS - 1)) && (short_ivl || group == GW'(GROUPS - 1));
    end

    // R10
    units_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        units < UW'(SHORT_SECS));

    // R10
    group_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        group < GW'(GROUPS));

endmodule

// File: rtl/drift_prescaler.sv
// Seconds prescaler with a per-period terminal count.
// Assumes PRESC_CYCLES exceeds the largest trim count.
module drift_prescaler
    import drift_trim_pkg::*;
#(
    parameter int PRESC_CYCLES = 32768,
    parameter int PW           = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply_add,
    input  logic               apply_sub,
    input  logic [TRIM_CW-1:0] trim_cnt,
    output logic               sec_tick,
    output logic [PW-1:0]      term
);

    localparam int MAX_TERM = PRESC_CYCLES - 1 + (1 << TRIM_CW) - 1;

    logic [PW-1:0] cnt;

    // Select this period's terminal count.
    always_comb begin
        term = PW'(PRESC_CYCLES - 1);
        if (apply_add)      term = PW'(PRESC_CYCLES - 1) - PW'(trim_cnt);
        else if (apply_sub) term = PW'(PRESC_CYCLES - 1) + PW'(trim_cnt);
    end

    // Fire the tick once the count reaches the terminal count.
    always_comb begin
        sec_tick = (cnt >= term);
    end

    // Count oscillator cycles and restart on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (sec_tick) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    // R1
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (cnt == '0));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= PW'(MAX_TERM));

endmodule

// File: rtl/drift_trim.sv
// Top of the drift trimmer.
// The trim is applied only on the prescaler period that closes an interval.
module drift_trim
    import drift_trim_pkg::*;
#(
    parameter int PRESC_CYCLES = 32768,
    parameter int SHORT_SECS   = 10,
    parameter int LONG_SECS    = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trim_wr,
    input  logic [7:0] trim_wdata,
    input  logic       ctl_wr,
    input  logic       ctl_trim_en,
    input  logic       ctl_short_ivl,
    output logic [7:0] trim_q,
    output logic       trim_en_q,
    output logic       short_ivl_q,
    output logic       sec_tick,
    output logic [$clog2(PRESC_CYCLES+64)-1:0] period_len
);

    localparam int PW = $clog2(PRESC_CYCLES + 64);

    trim_word_t word_q;
    logic       last_sec;
    logic       apply;

    drift_trim_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .trim_wr(trim_wr), .trim_wdata(trim_wdata),
        .ctl_wr(ctl_wr), .ctl_trim_en(ctl_trim_en), .ctl_short_ivl(ctl_short_ivl),
        .trim_q(word_q), .trim_en_q(trim_en_q), .short_ivl_q(short_ivl_q)
    );

    drift_sec_track #(.SHORT_SECS(SHORT_SECS), .LONG_SECS(LONG_SECS)) u_track (
        .clk(clk), .rst_n(rst_n),
        .sec_tick(sec_tick), .short_ivl(short_ivl_q), .last_sec(last_sec)
    );

    // Arm the trim only on the boundary period with trimming enabled.
    always_comb begin
        apply = trim_en_q && last_sec;
    end

    drift_prescaler #(.PRESC_CYCLES(PRESC_CYCLES), .PW(PW)) u_presc (
        .clk(clk), .rst_n(rst_n),
        .apply_add(apply && word_q.dir == DIR_ADD),
        .apply_sub(apply && word_q.dir == DIR_SUB),
        .trim_cnt(word_q.cnt),
        .sec_tick(sec_tick), .term(period_len)
    );

    // Expose the stored trim word.
    always_comb begin
        trim_q = word_q;
    end

    // R4
    nominal_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_sec |-> (period_len == PW'(PRESC_CYCLES - 1)));

    // R3
    trim_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trim_en_q |-> (period_len == PW'(PRESC_CYCLES - 1)));

    // R7
    no_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q.dir == DIR_NONE || word_q.dir == DIR_RSVD) |-> (period_len == PW'(PRESC_CYCLES - 1)));

endmodule

// File: tb/drift_trim_bench.sv
module drift_trim_bench;

    localparam int PRESC = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trim_wr = 1'b0;
    logic [7:0] trim_wdata = '0;
    logic       ctl_wr = 1'b0;
    logic       ctl_trim_en = 1'b0;
    logic       ctl_short_ivl = 1'b0;
    logic [7:0] trim_q;
    logic       trim_en_q, short_ivl_q, sec_tick;
    logic [$clog2(PRESC+64)-1:0] period_len;

    drift_trim #(.PRESC_CYCLES(PRESC)) u_drift_trim (
        .clk(clk), .rst_n(rst_n),
        .trim_wr(trim_wr), .trim_wdata(trim_wdata),
        .ctl_wr(ctl_wr), .ctl_trim_en(ctl_trim_en), .ctl_short_ivl(ctl_short_ivl),
        .trim_q(trim_q), .trim_en_q(trim_en_q), .short_ivl_q(short_ivl_q),
        .sec_tick(sec_tick), .period_len(period_len)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    int last_tick = 0;
    int sec_idx = 0;
    logic [7:0] m_trim = '0;
    logic       m_en = 1'b0, m_short = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (second %0d)", req, act, exp, sec_idx);
        end
    endtask

    // Expected period length of the second that ends now, with the requirement it tests.
    task automatic expect_period(output int len, output string req);
        int  iv = m_short ? 10 : 60;
        bit  last = (sec_idx % iv) == iv - 1;
        int  n = int'(m_trim[5:0]);
        len = PRESC;
        if (!m_en)                           req = "R3";
        else if (!last)                      req = "R4";
        else if (m_trim[7:6] == 2'd1) begin  len = PRESC - n; req = (n == 0) ? "R11" : "R5"; end
        else if (m_trim[7:6] == 2'd2) begin  len = PRESC + n; req = (n == 0) ? "R11" : "R6"; end
        else                                 req = "R7";
        if (m_en && last && m_short && req != "R7") req = {req, "/R8"};
    endtask

    // Wait for the next tick and check the length of the period it closes.
    task automatic run_secs(input int n);
        for (int i = 0; i < n; i++) begin
            int len; string req;
            do @(negedge clk); while (!sec_tick);
            expect_period(len, req);
            check(req, cyc - last_tick, len);
            last_tick = cyc;
            sec_idx++;
        end
    endtask

    task automatic write_trim(input logic [7:0] v);
        trim_wr = 1'b1; trim_wdata = v;
        @(negedge clk);
        trim_wr = 1'b0;
        m_trim = v;
        check("R2", int'(trim_q), int'(v));
    endtask

    task automatic write_ctl(input logic en, input logic sh);
        ctl_wr = 1'b1; ctl_trim_en = en; ctl_short_ivl = sh;
        @(negedge clk);
        ctl_wr = 1'b0;
        m_en = en;
        if (m_trim[7:6] == 2'd0) m_short = sh;
        check("R9", int'(trim_en_q), int'(m_en));
        check("R9", int'(short_ivl_q), int'(m_short));
    endtask

    initial begin
        #(5.0 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", int'(trim_q), 0);
        check("R1", int'(trim_en_q), 0);
        check("R1", int'(short_ivl_q), 0);
        check("R1", int'(sec_tick), 0);
        rst_n = 1'b1;
        last_tick = cyc - 1;
        run_secs(1);                 // R1 first tick after PRESC cycles

        // R3 trim off, armed subtract ignored
        write_trim({2'd2, 6'd63});
        run_secs(60);
        // R6 subtract in long mode, spans boundary at second 119
        write_ctl(1'b1, 1'b0);
        run_secs(60);
        // R5 add in long mode
        write_trim({2'd1, 6'd33});
        run_secs(60);
        // R7 reserved code in long mode
        write_trim({2'd3, 6'd20});
        run_secs(60);
        // R9 interval change refused while direction armed
        write_trim({2'd2, 6'd7});
        write_ctl(1'b1, 1'b1);
        run_secs(10);
        // R8 clear direction, then switch to short mode; R10 boundaries from reset
        write_trim(8'h00);
        write_ctl(1'b1, 1'b1);
        for (int d = 0; d < 4; d++) begin
            for (int n = 0; n < 64; n += 9) begin
                write_trim({d[1:0], n[5:0]});
                run_secs(10);
            end
            write_trim({d[1:0], 6'd63});
            run_secs(10);
        end
        // R8 back to long mode, subtract across a 60 s boundary
        write_trim(8'h00);
        write_ctl(1'b1, 1'b0);
        write_trim({2'd2, 6'd5});
        run_secs(60);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule